// File: doc/BRIEF.md
# Masked SIMD Bitwise XOR Unit

This execution unit computes the bitwise exclusive-OR of two source vectors and produces a new destination register value up to 512 bits wide. Each operation selects a vector length of 128, 256 or 512 bits and an element size of 32 or 64 bits. An encoding class decides how the unit treats the write mask, the broadcast control and the destination bits above the active length. The unit takes both sources and the old destination value, and it returns the new destination one clock later with a valid flag.

Only the masked class uses the per-element write mask, the merge-or-zero control and the broadcast control. A broadcast operand comes in already fetched, in the low element of the second source. Instruction decoding, memory access and exception handling take place outside the unit.

Top module: `vxor_unit`

## Requirements
- R1: Every result bit is 1 when the two source bits differ and 0 when they match. In the plain class (`cls`=2), destination bits below the vector length take `src_a ^ src_b`. The vector length code is 0=128, 1=256 and 2 or 3=512 bits.
- R2: In the masked class (`cls`=3) the active lane count is VL/32 when `elem64`=0 and VL/64 when `elem64`=1. That gives 4, 8 or 16 lanes, or 2, 4 or 8 lanes. Lane j covers bits j*E to j*E+E-1 and is controlled by `wmask[j]`.
- R3: In the masked class an active lane receives the XOR of its slices when its mask bit is 1 or when `mask_en`=0.
- R4: In the masked class with `mask_en`=1 and `zero_mode`=0, an active lane whose mask bit is 0 keeps its old destination bits.
- R5: In the masked class with `mask_en`=1 and `zero_mode`=1, an active lane whose mask bit is 0 becomes zero.
- R6: In the masked class with `bcast`=1 and `b_is_mem`=1, every lane uses the lowest element of `src_b` (bits E-1:0) in place of its own slice. With `b_is_mem`=0 the broadcast control has no effect.
- R7: In the masked class, every destination bit at or above the vector length becomes zero.
- R8: In the 128-bit legacy class (`cls`=1), bits 127:0 take `src_a ^ src_b` and bits 511:128 keep the old destination. In the plain class, bits at or above the vector length become zero.
- R9: In the 64-bit legacy class (`cls`=0) the destination is also the first source. Bits 63:0 take `old_dst ^ src_b`, `src_a` is ignored, and bits 511:64 keep the old destination.
- R10: Classes 0, 1 and 2 ignore `wmask`, `mask_en`, `zero_mode` and `bcast`, and they write every lane in their range.
- R11: Mask bits at or above the active lane count have no effect on the result.
- R12: `out_valid` equals `in_valid` from one cycle earlier, and `dst` is updated only in cycles where `in_valid`=1. An asynchronous active-low reset clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| cls | input | 2 | Encoding class: 0 legacy 64-bit, 1 legacy 128-bit, 2 plain, 3 masked |
| vlen | input | 2 | Vector length code: 0=128, 1=256, 2 or 3=512 |
| elem64 | input | 1 | Element size: 0=32-bit, 1=64-bit |
| mask_en | input | 1 | Write mask in use (masked class only) |
| zero_mode | input | 1 | 1 = zero masked-off lanes, 0 = merge |
| bcast | input | 1 | Broadcast control (masked class only) |
| b_is_mem | input | 1 | Second source came from memory |
| wmask | input | 16 | Per-lane write mask, bit j for lane j |
| src_a | input | 512 | First source |
| src_b | input | 512 | Second source, or the broadcast scalar in its low element |
| old_dst | input | 512 | Previous destination value |
| out_valid | output | 1 | Result valid |
| dst | output | 512 | New destination value |

## Verification
The assertions assume that the upstream logic keeps the data inputs stable in any cycle where `in_valid` is high. They also assume that `rst_n` is driven to known values from the first edge. The bench changes inputs only on falling clock edges and holds every operand for the full cycle. It runs every combination of class, length code, element size and masking controls with fresh operands each time. The lane-0 mask bit is forced to each value in turn, so that the merge and zero properties see both outcomes.

// File: rtl/vxor_pkg.sv
package vxor_pkg;
  localparam int unsigned CHUNK_W = 32;

  typedef enum logic [1:0] {
    CLS_LEG64  = 2'd0,
    CLS_LEG128 = 2'd1,
    CLS_PLAIN  = 2'd2,
    CLS_MASKED = 2'd3
  } enc_class_e;

  typedef enum logic [1:0] {
    VL_128  = 2'd0,
    VL_256  = 2'd1,
    VL_512  = 2'd2,
    VL_512B = 2'd3
  } vlen_e;
endpackage

// File: rtl/vxor_lane_ctl.sv
module vxor_lane_ctl
  import vxor_pkg::*;
#(
  parameter int unsigned MAX_W = 512,
  localparam int unsigned NCH = MAX_W / CHUNK_W,
  localparam int unsigned BASE_CH = 128 / CHUNK_W
) (
  input  logic [1:0]     vlen,
  input  logic           elem64,
  input  logic [1:0]     cls,
  input  logic           mask_en,
  input  logic [NCH-1:0] wmask,
  output logic [NCH-1:0] active,
  output logic [NCH-1:0] write
);
  int unsigned act_n;
  logic        masked_cls;

  always_comb begin
    case (vlen_e'(vlen))
      VL_128:  act_n = BASE_CH;
      VL_256:  act_n = BASE_CH * 2;
      default: act_n = BASE_CH * 4;
    endcase
    if (act_n > NCH) act_n = NCH;
  end

  assign masked_cls = (enc_class_e'(cls) == CLS_MASKED);

  for (genvar c = 0; c < NCH; c++) begin : g_chunk
    logic mbit;
    assign mbit      = elem64 ? wmask[c/2] : wmask[c];
    assign active[c] = (c < act_n);
    assign write[c]  = active[c] & (~masked_cls | ~mask_en | mbit);
  end
endmodule

// File: rtl/vxor_src_bcast.sv
module vxor_src_bcast
  import vxor_pkg::*;
#(
  parameter int unsigned MAX_W = 512,
  localparam int unsigned NCH = MAX_W / CHUNK_W
) (
  input  logic             bcast_on,
  input  logic             elem64,
  input  logic [MAX_W-1:0] src_b,
  output logic [MAX_W-1:0] src_b_eff
);
  for (genvar c = 0; c < NCH; c++) begin : g_chunk
    logic [CHUNK_W-1:0] scalar;
    assign scalar = elem64 ? src_b[(c%2)*CHUNK_W +: CHUNK_W] : src_b[CHUNK_W-1:0];
    assign src_b_eff[c*CHUNK_W +: CHUNK_W] = bcast_on ? scalar : src_b[c*CHUNK_W +: CHUNK_W];
  end
endmodule

// File: rtl/vxor_merge.sv
module vxor_merge
  import vxor_pkg::*;
#(
  parameter int unsigned MAX_W = 512,
  localparam int unsigned NCH = MAX_W / CHUNK_W,
  localparam int unsigned L64_CH = 64 / CHUNK_W,
  localparam int unsigned L128_CH = 128 / CHUNK_W
) (
  input  logic [1:0]       cls,
  input  logic             zero_mode,
  input  logic [NCH-1:0]   active,
  input  logic [NCH-1:0]   write,
  input  logic [MAX_W-1:0] src_a,
  input  logic [MAX_W-1:0] src_b_eff,
  input  logic [MAX_W-1:0] old_dst,
  output logic [MAX_W-1:0] result
);
  for (genvar c = 0; c < NCH; c++) begin : g_chunk
    logic [CHUNK_W-1:0] a_w, b_w, o_w, r_w;
    assign a_w = src_a[c*CHUNK_W +: CHUNK_W];
    assign b_w = src_b_eff[c*CHUNK_W +: CHUNK_W];
    assign o_w = old_dst[c*CHUNK_W +: CHUNK_W];

    always_comb begin
      case (enc_class_e'(cls))
        CLS_LEG64:  r_w = (c < L64_CH)  ? (o_w ^ b_w) : o_w;
        CLS_LEG128: r_w = (c < L128_CH) ? (a_w ^ b_w) : o_w;
        CLS_PLAIN:  r_w = write[c] ? (a_w ^ b_w) : '0;
        default: begin
          if (!active[c])    r_w = '0;
          else if (write[c]) r_w = a_w ^ b_w;
          else if (zero_mode) r_w = '0;
          else               r_w = o_w;
        end
      endcase
    end

    assign result[c*CHUNK_W +: CHUNK_W] = r_w;
  end
endmodule

// File: rtl/vxor_unit.sv
module vxor_unit
  import vxor_pkg::*;
#(
  parameter int unsigned MAX_W = 512,
  localparam int unsigned NCH = MAX_W / CHUNK_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       cls,
  input  logic [1:0]       vlen,
  input  logic             elem64,
  input  logic             mask_en,
  input  logic             zero_mode,
  input  logic             bcast,
  input  logic             b_is_mem,
  input  logic [NCH-1:0]   wmask,
  input  logic [MAX_W-1:0] src_a,
  input  logic [MAX_W-1:0] src_b,
  input  logic [MAX_W-1:0] old_dst,
  output logic             out_valid,
  output logic [MAX_W-1:0] dst
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  logic [NCH-1:0]   active, write;
  logic             bcast_on;
  logic [MAX_W-1:0] src_b_eff, result;

  assign bcast_on = (enc_class_e'(cls) == CLS_MASKED) & bcast & b_is_mem;

  vxor_lane_ctl #(.MAX_W(MAX_W)) u_lane_ctl (
    .vlen(vlen), .elem64(elem64), .cls(cls), .mask_en(mask_en),
    .wmask(wmask), .active(active), .write(write)
  );

  vxor_src_bcast #(.MAX_W(MAX_W)) u_bcast (
    .bcast_on(bcast_on), .elem64(elem64), .src_b(src_b), .src_b_eff(src_b_eff)
  );

  vxor_merge #(.MAX_W(MAX_W)) u_merge (
    .cls(cls), .zero_mode(zero_mode), .active(active), .write(write),
    .src_a(src_a), .src_b_eff(src_b_eff), .old_dst(old_dst), .result(result)
  );

  // next-state
  logic             vld_d, vld_q;
  logic             dst_en;
  logic [MAX_W-1:0] dst_d, dst_q;

  always_comb begin
    vld_d  = in_valid;
    dst_en = in_valid;
    dst_d  = result;
  end

  // registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) vld_q <= 1'b0;
    else          vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (dst_en) dst_q <= dst_d;
  end

  assign out_valid = vld_q;
  assign dst       = dst_q;

  // assertions
  assert_valid_follows_R12: assert property (@(posedge clk) disable iff (!rst_s_n)
    out_valid == $past(in_valid));

  assert_hold_when_idle_R12: assert property (@(posedge clk) disable iff (!rst_s_n)
    !in_valid |=> $stable(dst));

  assert_plain_xor_R1: assert property (@(posedge clk) disable iff (!rst_s_n)
    (in_valid && cls == 2'd2) |=> dst[127:0] == $past(src_a[127:0] ^ src_b[127:0]));

  assert_masked_upper_clear_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (in_valid && cls == 2'd3 && vlen == 2'd0) |=> dst[MAX_W-1:128] == '0);

  assert_leg128_upper_keep_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (in_valid && cls == 2'd1) |=> dst[MAX_W-1:128] == $past(old_dst[MAX_W-1:128]));

  assert_leg64_twoop_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (in_valid && cls == 2'd0) |=> dst[63:0] == $past(old_dst[63:0] ^ src_b[63:0]));

  assert_merge_keep_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (in_valid && cls == 2'd3 && mask_en && !zero_mode && !wmask[0])
      |=> dst[31:0] == $past(old_dst[31:0]));

  assert_zero_clear_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (in_valid && cls == 2'd3 && mask_en && zero_mode && !wmask[0])
      |=> dst[31:0] == '0);
endmodule

// File: tb/tb_vxor_unit.sv
module tb_vxor_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W = 512;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           in_valid;
  logic [1:0]     cls, vlen;
  logic           elem64, mask_en, zero_mode, bcast, b_is_mem;
  logic [15:0]    wmask;
  logic [W-1:0]   src_a, src_b, old_dst;
  logic           out_valid;
  logic [W-1:0]   dst;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vxor_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cls(cls), .vlen(vlen),
    .elem64(elem64), .mask_en(mask_en), .zero_mode(zero_mode), .bcast(bcast),
    .b_is_mem(b_is_mem), .wmask(wmask), .src_a(src_a), .src_b(src_b),
    .old_dst(old_dst), .out_valid(out_valid), .dst(dst)
  );

  function automatic logic [W-1:0] rnd512();
    logic [W-1:0] v;
    for (int i = 0; i < W/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  // expected destination computed from the requirements, lane by lane
  function automatic logic [W-1:0] expect_dst(
      input logic [1:0] c, input logic [1:0] vl, input logic e64,
      input logic men, input logic zm, input logic bc, input logic mem,
      input logic [15:0] m, input logic [W-1:0] a, input logic [W-1:0] b,
      input logic [W-1:0] o);
    logic [W-1:0] r;
    int bits  = (vl == 2'd0) ? 128 : (vl == 2'd1) ? 256 : 512;
    int esz   = e64 ? 64 : 32;
    r = o;
    case (c)
      2'd0: for (int i = 0; i < 64; i++)  r[i] = o[i] ^ b[i];
      2'd1: for (int i = 0; i < 128; i++) r[i] = a[i] ^ b[i];
      2'd2: for (int i = 0; i < W; i++)   r[i] = (i < bits) ? (a[i] ^ b[i]) : 1'b0;
      default: begin
        r = '0;
        for (int j = 0; j < bits/esz; j++)
          for (int k = 0; k < esz; k++) begin
            int  i  = j*esz + k;
            logic bb = (bc && mem) ? b[k] : b[i];
            if (!men || m[j]) r[i] = a[i] ^ bb;
            else              r[i] = zm ? 1'b0 : o[i];
          end
      end
    endcase
    return r;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(input string tag, input logic [1:0] c, input logic [1:0] vl,
      input logic e64, input logic men, input logic zm, input logic bc, input logic mem,
      input logic [15:0] m, input logic [W-1:0] a, input logic [W-1:0] b,
      input logic [W-1:0] o);
    logic [W-1:0] exp;
    @(negedge clk);
    in_valid = 1; cls = c; vlen = vl; elem64 = e64; mask_en = men; zero_mode = zm;
    bcast = bc; b_is_mem = mem; wmask = m; src_a = a; src_b = b; old_dst = o;
    exp = expect_dst(c, vl, e64, men, zm, bc, mem, m, a, b, o);
    @(negedge clk);
    in_valid = 0;
    check({tag, " valid"}, {{(W-1){1'b0}}, out_valid}, {{(W-1){1'b0}}, 1'b1});
    check(tag, dst, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] a, b, o, hold;
    rst_n = 0; in_valid = 0; cls = 0; vlen = 0; elem64 = 0; mask_en = 0;
    zero_mode = 0; bcast = 0; b_is_mem = 0; wmask = 0;
    src_a = '0; src_b = '0; old_dst = '0;
    repeat (3) @(negedge clk);
    check("R12 reset valid", {{(W-1){1'b0}}, out_valid}, '0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R12 idle valid", {{(W-1){1'b0}}, out_valid}, '0);

    // full sweep over classes and controls
    for (int c = 0; c < 4; c++)
      for (int vl = 0; vl < 4; vl++)
        for (int ctl = 0; ctl < 32; ctl++)
          for (int m0 = 0; m0 < 2; m0++) begin
            logic [15:0] m = 16'($urandom);
            string t;
            m[0] = m0[0];
            t = (c == 0) ? "R9" : (c == 1) ? "R8" : (c == 2) ? "R1" : "R3";
            run_op(t, 2'(c), 2'(vl), ctl[0], ctl[1], ctl[2], ctl[3], ctl[4],
                   m, rnd512(), rnd512(), rnd512());
          end

    // R2: lane counts with all mask bits set, merge of all-ones old
    for (int vl = 0; vl < 3; vl++)
      for (int e = 0; e < 2; e++)
        run_op("R2", 2'd3, 2'(vl), e[0], 1, 0, 0, 0, 16'hFFFF,
               rnd512(), rnd512(), {W{1'b1}});

    // R4 / R5: alternating mask, merge vs zero
    a = rnd512(); b = rnd512(); o = rnd512();
    run_op("R4", 2'd3, 2'd2, 0, 1, 0, 0, 0, 16'h5555, a, b, o);
    run_op("R5", 2'd3, 2'd2, 0, 1, 1, 0, 0, 16'h5555, a, b, o);
    run_op("R5", 2'd3, 2'd2, 1, 1, 1, 0, 0, 16'h00AA, a, b, o);

    // R6: broadcast only with memory source
    run_op("R6", 2'd3, 2'd2, 0, 0, 0, 1, 1, 16'h0, a, b, o);
    run_op("R6", 2'd3, 2'd2, 1, 0, 0, 1, 1, 16'h0, a, b, o);
    run_op("R6", 2'd3, 2'd2, 0, 0, 0, 1, 0, 16'h0, a, b, o);

    // R7: masked class upper bits cleared
    run_op("R7", 2'd3, 2'd0, 1, 0, 0, 0, 0, 16'h0, a, b, {W{1'b1}});
    run_op("R7", 2'd3, 2'd1, 0, 1, 0, 0, 0, 16'hFFFF, a, b, {W{1'b1}});

    // R10: non-masked classes ignore masking and broadcast
    run_op("R10", 2'd2, 2'd1, 0, 1, 1, 1, 1, 16'h0000, a, b, o);
    run_op("R10", 2'd1, 2'd0, 0, 1, 1, 1, 1, 16'h0000, a, b, o);
    run_op("R10", 2'd0, 2'd2, 1, 1, 1, 1, 1, 16'h0000, a, b, o);

    // R11: mask bits beyond active lanes
    run_op("R11", 2'd3, 2'd0, 0, 1, 0, 0, 0, 16'hFFF0, a, b, o);
    run_op("R11", 2'd3, 2'd1, 1, 1, 1, 0, 0, 16'hFFF0, a, b, o);

    // R12: dst held and valid low during an idle cycle
    hold = dst;
    @(negedge clk);
    src_a = rnd512(); src_b = rnd512(); old_dst = rnd512();
    @(negedge clk);
    check("R12 idle valid", {{(W-1){1'b0}}, out_valid}, '0);
    check("R12 hold", dst, hold);

    // R12: reset mid-run clears valid
    @(negedge clk);
    in_valid = 1;
    @(negedge clk);
    rst_n = 0;
    #1;
    check("R12 async reset", {{(W-1){1'b0}}, out_valid}, '0);
    in_valid = 0;
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule